// File: doc/BRIEF.md
# Audio Serial Bit and Word Clock Master

This block drives the bit clock and the word clock of an audio serial port when the port owns the bus timing. It runs from a reference clock at 512 times the sample rate; one sample frame is 512 reference cycles. Within each frame it issues a programmed number of bit periods. That number is twice the channel slot width in continuous mode, or a fixed 256 in fixed-count mode. When that number does not divide 512, a phase accumulator places the bit edges. Individual bit periods then differ by one reference cycle, but every frame still holds exactly the programmed count.

Alongside the clocks it gives the serial data port a one-cycle strobe at the start of every bit and a second strobe at the start of every frame, together with the index of the current bit. The word clock is either a square wave covering the first channel slot or a single-bit pulse at the frame start. The two clock pins each have their own master enable. When a pin is not mastered it is held low and its output enable is dropped, while the internal timing and the strobes keep running. Configuration inputs are sampled only in the last reference cycle of a frame, so a frame never mixes two settings.

Top module: `audio_clk_master`

## Requirements
- R1: A frame lasts exactly 512 reference cycles. `frame_stb` is high for one cycle at the start of each frame, and the first frame starts in the second cycle after reset is released.
- R2: In continuous mode (`cfg_fixed256`=0) a frame holds 2×W bit periods. W is 16, 20, 24 or 32 for `cfg_width` codes 0, 1, 2 and 3.
- R3: With `cfg_fixed256`=1 a frame holds 256 bit periods, whatever the value of `cfg_width`.
- R4: For 32 and 64 bits per frame, every bit period lasts 16 and 8 reference cycles respectively. In fixed-count mode every bit period lasts 2 cycles.
- R5: For 40 bits per frame every bit period lasts 12 or 13 cycles, and for 48 bits it lasts 10 or 11 cycles. The frame total is still 512 cycles.
- R6: `bclk_o` is low in the first cycle of each bit and rises once within the bit. `bit_stb` marks that first cycle. `bit_idx` counts 0 to N-1 across the frame, and the frame's first bit coincides with `frame_stb`.
- R7: With `cfg_wclk_pulse`=0, `wclk_o` goes high in the first cycle of the frame and stays high for the first N/2 bits, which is exactly 256 reference cycles.
- R8: With `cfg_wclk_pulse`=1, `wclk_o` is high only during bit 0 of each frame: 16, 13, 11, 8 or 2 cycles for 32, 40, 48, 64 or 256 bits.
- R9: The width, mode and word-clock shape are sampled only in the last cycle of a frame and govern the whole following frame. A change at any other time has no effect on the current frame.
- R10: `bclk_oe` and `wclk_oe` follow `bclk_master` and `wclk_master` one cycle later, and each pin is held low while its enable is off. The strobes keep running either way.
- R11: During reset both clock pins, both enables and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 512 cycles per sample frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Slot width code: 0=16, 1=20, 2=24, 3=32 bits |
| cfg_fixed256 | input | 1 | 1: 256 bits per frame; 0: twice the slot width |
| cfg_wclk_pulse | input | 1 | 1: word clock is a one-bit pulse; 0: square wave |
| bclk_master | input | 1 | Drive the bit clock pin |
| wclk_master | input | 1 | Drive the word clock pin |
| bclk_o | output | 1 | Bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| wclk_o | output | 1 | Word clock |
| wclk_oe | output | 1 | Word clock output enable |
| bit_stb | output | 1 | First reference cycle of each bit |
| frame_stb | output | 1 | First reference cycle of each frame |
| bit_idx | output | 8 | Index of the current bit within the frame |

## Verification
The frame-boundary reload coincides with a configuration change when new settings arrive in the last reference cycle of a frame. In that same cycle the accumulator's final overflow also meets the forced restart. The bench changes the inputs in exactly that cycle and checks that the next frame follows the new setting in full, with correct bit count, period lengths and word clock. A separate case changes the inputs right after a frame starts and expects the running frame to keep the old count.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [1:0] {
        WID_16 = 2'd0,
        WID_20 = 2'd1,
        WID_24 = 2'd2,
        WID_32 = 2'd3
    } slot_width_e;

    typedef struct packed {
        slot_width_e width;
        logic        fixed_count;
        logic        wclk_pulse;
    } clk_cfg_t;

    typedef struct packed {
        clk_cfg_t cfg;
        logic     bclk_oe;
        logic     wclk_oe;
    } top_state_t;

    localparam clk_cfg_t CFG_RESET = '{width: WID_16, fixed_count: 1'b0, wclk_pulse: 1'b0};

    // Bit periods per frame for a configuration.
    function automatic logic [15:0] frame_bits(clk_cfg_t c, int unsigned fixed_bits);
        logic [15:0] n;
        if (c.fixed_count) begin
            n = 16'(fixed_bits);
        end else begin
            case (c.width)
                WID_16:  n = 16'd32;
                WID_20:  n = 16'd40;
                WID_24:  n = 16'd48;
                default: n = 16'd64;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer #(
    parameter int unsigned REF_CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_o
);
    localparam int unsigned CNT_W = $clog2(REF_CYCLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Reset parks the counter on the last cycle so a frame opens right after release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LAST_CNT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == LAST_CNT);

endmodule

// File: rtl/aclk_edge_accum.sv
module aclk_edge_accum #(
    parameter int unsigned REF_CYCLES = 512,
    parameter int unsigned ACC_W      = 9,
    parameter int unsigned SUM_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] step_i,
    input  logic             restart_i,
    output logic             toggle_o
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [SUM_W-1:0] sum;
    logic             wrap;
    logic [ACC_W-1:0] acc_wrapped;

    assign sum = {1'b0, acc_q} + step_i;

    // A power-of-two modulus wraps by dropping the carry; otherwise subtract.
    generate
        if ((REF_CYCLES & (REF_CYCLES - 1)) == 0) begin : g_pow2
            assign wrap        = sum[SUM_W-1];
            assign acc_wrapped = sum[ACC_W-1:0];
        end else begin : g_general
            logic [SUM_W-1:0] sum_less;
            assign wrap        = (sum >= SUM_W'(REF_CYCLES));
            assign sum_less    = sum - SUM_W'(REF_CYCLES);
            assign acc_wrapped = sum_less[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        if (restart_i) begin
            acc_d    = '0;
            toggle_o = 1'b1;
        end else if (wrap) begin
            acc_d    = acc_wrapped;
            toggle_o = 1'b1;
        end else begin
            acc_d    = sum[ACC_W-1:0];
            toggle_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/aclk_bit_seq.sv
module aclk_bit_seq #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned NB_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             toggle_i,
    input  logic [NB_W-1:0]  nbits_i,
    input  logic             pulse_i,
    output logic             bclk_o,
    output logic             bit_stb_o,
    output logic             frame_stb_o,
    output logic             wclk_o,
    output logic [IDX_W-1:0] bit_idx_o
);
    typedef struct packed {
        logic             bclk;
        logic             bit_stb;
        logic             frame_stb;
        logic             wclk;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t            seq_d, seq_q;
    logic [NB_W-1:0] half_bits;

    assign half_bits = nbits_i >> 1;

    always_comb begin
        seq_d           = seq_q;
        seq_d.bit_stb   = 1'b0;
        seq_d.frame_stb = 1'b0;
        if (restart_i) begin
            seq_d.bclk      = 1'b0;
            seq_d.bit_stb   = 1'b1;
            seq_d.frame_stb = 1'b1;
            seq_d.idx       = '0;
        end else if (toggle_i) begin
            seq_d.bclk = ~seq_q.bclk;
            // A falling toggle opens the next bit.
            if (seq_q.bclk) begin
                seq_d.bit_stb = 1'b1;
                seq_d.idx     = seq_q.idx + 1'b1;
            end
        end
        if (pulse_i) begin
            seq_d.wclk = (seq_d.idx == '0);
        end else begin
            seq_d.wclk = ({1'b0, seq_d.idx} < half_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bclk_o      = seq_q.bclk;
    assign bit_stb_o   = seq_q.bit_stb;
    assign frame_stb_o = seq_q.frame_stb;
    assign wclk_o      = seq_q.wclk;
    assign bit_idx_o   = seq_q.idx;

endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master #(
    parameter int unsigned REF_CYCLES = 512,
    parameter int unsigned FIXED_BITS = 256,
    localparam int unsigned IDX_W     = $clog2(FIXED_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_fixed256,
    input  logic             cfg_wclk_pulse,
    input  logic             bclk_master,
    input  logic             wclk_master,
    output logic             bclk_o,
    output logic             bclk_oe,
    output logic             wclk_o,
    output logic             wclk_oe,
    output logic             bit_stb,
    output logic             frame_stb,
    output logic [IDX_W-1:0] bit_idx
);
    import aclk_pkg::*;

    localparam int unsigned NB_W  = IDX_W + 1;
    localparam int unsigned ACC_W = $clog2(REF_CYCLES);
    localparam int unsigned SUM_W = ACC_W + 1;

    top_state_t      cur_d, cur_q;
    clk_cfg_t        cfg_in;
    clk_cfg_t        cfg_q;
    logic            frame_last;
    logic            edge_toggle;
    logic [NB_W-1:0] nbits_next;
    logic [NB_W-1:0] nbits_now;
    logic [SUM_W-1:0] step;
    logic            bclk_raw;
    logic            wclk_raw;

    assign cfg_in = '{width: slot_width_e'(cfg_width),
                      fixed_count: cfg_fixed256,
                      wclk_pulse: cfg_wclk_pulse};

    always_comb begin
        cur_d         = cur_q;
        cur_d.bclk_oe = bclk_master;
        cur_d.wclk_oe = wclk_master;
        if (frame_last) begin
            cur_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cfg: CFG_RESET, bclk_oe: 1'b0, wclk_oe: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign cfg_q      = cur_q.cfg;
    assign nbits_now  = NB_W'(frame_bits(cur_q.cfg, FIXED_BITS));
    assign nbits_next = NB_W'(frame_bits(cur_d.cfg, FIXED_BITS));
    assign step       = SUM_W'({nbits_now, 1'b0});

    aclk_frame_timer #(
        .REF_CYCLES(REF_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_o (frame_last)
    );

    aclk_edge_accum #(
        .REF_CYCLES(REF_CYCLES),
        .ACC_W     (ACC_W),
        .SUM_W     (SUM_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (frame_last),
        .toggle_o  (edge_toggle)
    );

    aclk_bit_seq #(
        .IDX_W(IDX_W),
        .NB_W (NB_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (frame_last),
        .toggle_i    (edge_toggle),
        .nbits_i     (nbits_next),
        .pulse_i     (cur_d.cfg.wclk_pulse),
        .bclk_o      (bclk_raw),
        .bit_stb_o   (bit_stb),
        .frame_stb_o (frame_stb),
        .wclk_o      (wclk_raw),
        .bit_idx_o   (bit_idx)
    );

    assign bclk_oe = cur_q.bclk_oe;
    assign wclk_oe = cur_q.wclk_oe;
    assign bclk_o  = bclk_raw & cur_q.bclk_oe;
    assign wclk_o  = wclk_raw & cur_q.wclk_oe;

endmodule

// File: rtl/aclk_checker.sv
module aclk_checker #(
    parameter int unsigned REF_CYCLES = 512,
    parameter int unsigned IDX_W      = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bclk_master,
    input logic                bclk_o,
    input logic                bclk_oe,
    input logic                wclk_o,
    input logic                wclk_oe,
    input logic                bit_stb,
    input logic                frame_stb,
    input logic [IDX_W-1:0]    bit_idx,
    input aclk_pkg::clk_cfg_t  cfg_now
);
    localparam int unsigned GAP_W = $clog2(REF_CYCLES) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && seen_q |-> gap_q == GAP_W'(REF_CYCLES - 1));

    assert_frame_opens_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> bit_stb);

    assert_bit_starts_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb && bclk_oe |-> !bclk_o);

    assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb && !frame_stb |-> bit_idx == IDX_W'($past(bit_idx) + 1'b1));

    assert_wclk_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wclk_oe) && $rose(wclk_o) |-> frame_stb);

    assert_pulse_one_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_now.wclk_pulse && wclk_o && !frame_stb |-> !bit_stb);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> $stable(cfg_now));

    assert_oe_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_master |=> bclk_oe);

    assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_master |=> !bclk_o);

endmodule

bind audio_clk_master aclk_checker #(
    .REF_CYCLES(REF_CYCLES),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_master (bclk_master),
    .bclk_o      (bclk_o),
    .bclk_oe     (bclk_oe),
    .wclk_o      (wclk_o),
    .wclk_oe     (wclk_oe),
    .bit_stb     (bit_stb),
    .frame_stb   (frame_stb),
    .bit_idx     (bit_idx),
    .cfg_now     (cfg_q)
);

// File: tb/audio_clk_master_test.sv
`timescale 1ns/1ps
module audio_clk_master_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_width;
    logic       cfg_fixed256;
    logic       cfg_wclk_pulse;
    logic       bclk_master;
    logic       wclk_master;
    logic       bclk_o, bclk_oe, wclk_o, wclk_oe, bit_stb, frame_stb;
    logic [7:0] bit_idx;

    always #2.5 clk = ~clk;

    audio_clk_master uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_width      (cfg_width),
        .cfg_fixed256   (cfg_fixed256),
        .cfg_wclk_pulse (cfg_wclk_pulse),
        .bclk_master    (bclk_master),
        .wclk_master    (wclk_master),
        .bclk_o         (bclk_o),
        .bclk_oe        (bclk_oe),
        .wclk_o         (wclk_o),
        .wclk_oe        (wclk_oe),
        .bit_stb        (bit_stb),
        .frame_stb      (frame_stb),
        .bit_idx        (bit_idx)
    );

    int n_run  = 0;
    int n_fail = 0;

    // width code, fixed mode, bits per frame, min period, max period, pulse length
    localparam int TBL [5][6] = '{
        '{0, 0,  32, 16, 16, 16},
        '{1, 0,  40, 12, 13, 13},
        '{2, 0,  48, 10, 11, 11},
        '{3, 0,  64,  8,  8,  8},
        '{1, 1, 256,  2,  2,  2}
    };

    int m_cyc, m_bits, m_rise, m_pmin, m_pmax, m_whigh, m_wfirst, m_maxidx, m_wstart;

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(int w, int fx, int pl);
        cfg_width      = 2'(w);
        cfg_fixed256   = fx[0];
        cfg_wclk_pulse = pl[0];
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!frame_stb);
    endtask

    // Entered at the negedge of a frame's first cycle; leaves at the next one.
    task automatic measure();
        int  pos      = 0;
        int  last_stb = 0;
        logic prev_b  = 1'b0;
        bit  run      = 1'b1;
        bit  busy     = 1'b1;
        m_bits = 0; m_rise = 0; m_pmin = 1 << 20; m_pmax = 0;
        m_whigh = 0; m_wfirst = 0; m_maxidx = 0;
        m_wstart = int'(wclk_o);
        while (busy) begin
            if (bit_stb) begin
                m_bits++;
                if (pos > 0) begin
                    if (pos - last_stb < m_pmin) m_pmin = pos - last_stb;
                    if (pos - last_stb > m_pmax) m_pmax = pos - last_stb;
                    last_stb = pos;
                end
            end
            if (bclk_o && !prev_b) m_rise++;
            prev_b = bclk_o;
            if (wclk_o) m_whigh++;
            if (wclk_o && run) m_wfirst++; else run = 1'b0;
            if (int'(bit_idx) > m_maxidx) m_maxidx = int'(bit_idx);
            @(negedge clk);
            pos++;
            if (frame_stb) busy = 1'b0;
        end
        if (pos - last_stb < m_pmin) m_pmin = pos - last_stb;
        if (pos - last_stb > m_pmax) m_pmax = pos - last_stb;
        m_cyc = pos;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        apply(0, 0, 0);
        bclk_master = 1'b1;
        wclk_master = 1'b1;
        repeat (4) @(negedge clk);
        check("R11", "bclk_o in reset",    int'(bclk_o),    0);
        check("R11", "wclk_o in reset",    int'(wclk_o),    0);
        check("R11", "bclk_oe in reset",   int'(bclk_oe),   0);
        check("R11", "wclk_oe in reset",   int'(wclk_oe),   0);
        check("R11", "bit_stb in reset",   int'(bit_stb),   0);
        check("R11", "frame_stb in reset", int'(frame_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "first frame after reset", int'(frame_stb), 1);
        check("R6", "first bit strobe",        int'(bit_stb),   1);
        check("R10", "bclk_oe after reset",    int'(bclk_oe),   1);

        // Vector table: square then pulse word clock for each setting.
        for (int i = 0; i < 5; i++) begin
            apply(TBL[i][0], TBL[i][1], 0);
            wait_frame();
            measure();
            check("R1", "frame length", m_cyc, 512);
            check(TBL[i][1] != 0 ? "R3" : "R2", "bit strobes", m_bits, TBL[i][2]);
            check("R6", "bclk rises", m_rise, TBL[i][2]);
            check("R6", "last bit index", m_maxidx, TBL[i][2] - 1);
            check(TBL[i][3] == TBL[i][4] ? "R4" : "R5", "min period", m_pmin, TBL[i][3]);
            check(TBL[i][3] == TBL[i][4] ? "R4" : "R5", "max period", m_pmax, TBL[i][4]);
            check("R7", "wclk high at frame start", m_wstart, 1);
            check("R7", "square wclk high cycles", m_whigh, 256);
            apply(TBL[i][0], TBL[i][1], 1);
            wait_frame();
            measure();
            check("R8", "pulse first run", m_wfirst, TBL[i][5]);
            check("R8", "pulse total high", m_whigh, TBL[i][5]);
        end

        // R3: fixed mode ignores the width code.
        apply(3, 1, 0);
        wait_frame();
        measure();
        check("R3", "fixed mode with width code 3", m_bits, 256);

        // R9: change early in a frame; the running frame keeps the old count.
        apply(0, 0, 0);
        measure();
        check("R9", "old setting kept in frame", m_bits, 256);
        measure();
        check("R9", "new setting next frame", m_bits, 32);

        // R9: change in the last cycle of a frame, coinciding with the reload.
        repeat (511) @(negedge clk);
        check("R9", "still inside frame at cycle 511", int'(frame_stb), 0);
        apply(3, 0, 0);
        @(negedge clk);
        check("R1", "frame opens after 512 cycles", int'(frame_stb), 1);
        measure();
        check("R9", "late change bits", m_bits, 64);
        check("R9", "late change period", m_pmax, 8);
        check("R9", "late change wclk", m_whigh, 256);

        // R10: bit clock released, word clock mastered.
        bclk_master = 1'b0;
        wait_frame();
        measure();
        check("R10", "bclk_oe released", int'(bclk_oe), 0);
        check("R10", "bclk pin rises when released", m_rise, 0);
        check("R10", "strobes continue", m_bits, 64);
        check("R10", "wclk still driven", m_whigh, 256);

        // R10: word clock released, bit clock mastered.
        bclk_master = 1'b1;
        wclk_master = 1'b0;
        wait_frame();
        measure();
        check("R10", "wclk_oe released", int'(wclk_oe), 0);
        check("R10", "wclk pin high when released", m_whigh, 0);
        check("R10", "bclk driven again", m_rise, 64);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule